// File: doc/BRIEF.md
# Pipelined CPU Execute Stage

This block is the execute stage of a simple 64-bit in-order pipeline. Each cycle it receives an instruction code, a function code, two register operands (`valA`, `valB`) and an immediate (`valC`). From the instruction code it chooses the two ALU inputs. These are register values, the immediate, a fixed stack step of plus or minus 8, or zero. It then applies one of four ALU operations and drives the result on `valE`.

A three-bit condition-code register holds zero, sign and overflow flags. Only arithmetic/logic instructions update it, and only when the stage is not stalled. A condition evaluator reads the stored flags together with the function code and produces `cnd`. The same output feeds next-PC selection for conditional jumps and the write-back enable for conditional moves. Fetch, decode, memory, write back and hazard handling are outside this block.

Top module: `exe_stage`

## Requirements
- R1: For instruction code 6 (arithmetic/logic), the low two bits of `ifun` select the operation: 0 gives valB+valA, 1 gives valB−valA, 2 gives valB&valA, 3 gives valB^valA. All are modulo 2^64 and appear on `valE` in the same cycle.
- R2: For instruction code 2 (register move or conditional move), `valE` = valA. For code 3 (immediate move), `valE` = valC.
- R3: For codes 4 and 5 (store and load addressing), `valE` = valB + valC.
- R4: For codes 8 and 0xA (call, push), `valE` = valB − 8. For codes 9 and 0xB (return, pop), `valE` = valB + 8.
- R5: For codes 0, 1, 7 and 0xC to 0xF, both ALU inputs are zero, so `valE` = 0.
- R6: `ccFlags` is {ZF, SF, OF} at bit positions 2, 1 and 0.
  - After a rising edge that captures an arithmetic/logic instruction, ZF = (result == 0) and SF = result bit 63.
  - For add, OF is set when both operands have the same sign and the sign of the result differs from theirs.
  - For subtract (valB−valA), OF is set when valB and valA have different signs and the sign of the result differs from the sign of valB.
  - For AND and XOR, OF is 0.
- R7: The flag register changes only on a rising edge where the instruction code is 6 and `stall` is low. With any other code, or while stalled, it holds its value.
- R8: While the active-low `rst_n` is asserted, `ccFlags` is 3'b100 (ZF=1, SF=0, OF=0).
- R9: `cnd` is a function of the stored flags and `ifun`, using L = SF^OF:

  | ifun | cnd |
  |------|-----|
  | 0 | 1 |
  | 1 | L \| ZF |
  | 2 | L |
  | 3 | ZF |
  | 4 | ~ZF |
  | 5 | ~L |
  | 6 | ~L & ~ZF |
  | 7 to 15 | 0 |

- R10: `cnd` is combinational from the stored flags and does not depend on the instruction code. Jumps and conditional moves therefore see the same value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset of the flag register |
| stall | input | 1 | Blocks the flag register update when high |
| icode | input | 4 | Instruction code |
| ifun | input | 4 | Function code (ALU operation or condition) |
| valA | input | 64 | First register operand |
| valB | input | 64 | Second register operand |
| valC | input | 64 | Immediate value |
| valE | output | 64 | ALU result |
| cnd | output | 1 | Evaluated jump / conditional-move condition |
| ccFlags | output | 3 | Stored flags {ZF, SF, OF} |

## Verification
`valE` and `cnd` are combinational, so they are due in the same cycle as the inputs. The bench drives inputs at the falling edge and samples both outputs 1 ns later, before the next rising edge. The stored flags are due one rising edge after the instruction that writes them. They are sampled 1 ns after that edge and compared with a flag model that the bench advances only for unstalled arithmetic instructions. Because `cnd` is checked against the model's flags from before the edge, a design that bypasses the register and reads the current ALU result would be caught.

// File: rtl/exe_pkg.sv
package exe_pkg;

  localparam int XLEN_DEF = 64;
  localparam int STEP_DEF = 8;

  // Instruction codes
  localparam logic [3:0] IC_HALT  = 4'h0;
  localparam logic [3:0] IC_NOP   = 4'h1;
  localparam logic [3:0] IC_MOVE  = 4'h2;
  localparam logic [3:0] IC_IMOV  = 4'h3;
  localparam logic [3:0] IC_STORE = 4'h4;
  localparam logic [3:0] IC_LOAD  = 4'h5;
  localparam logic [3:0] IC_ALU   = 4'h6;
  localparam logic [3:0] IC_JUMP  = 4'h7;
  localparam logic [3:0] IC_CALL  = 4'h8;
  localparam logic [3:0] IC_RET   = 4'h9;
  localparam logic [3:0] IC_PUSH  = 4'hA;
  localparam logic [3:0] IC_POP   = 4'hB;

  // Condition function codes
  localparam logic [3:0] CC_ALWAYS = 4'h0;
  localparam logic [3:0] CC_LE     = 4'h1;
  localparam logic [3:0] CC_LT     = 4'h2;
  localparam logic [3:0] CC_EQ     = 4'h3;
  localparam logic [3:0] CC_NE     = 4'h4;
  localparam logic [3:0] CC_GE     = 4'h5;
  localparam logic [3:0] CC_GT     = 4'h6;

  // Flag register layout and reset value
  localparam int ZF_BIT = 2;
  localparam int SF_BIT = 1;
  localparam int OF_BIT = 0;
  localparam logic [2:0] FLAGS_RESET = 3'b100;

  typedef enum logic [2:0] {
    SRC_A_ZERO,
    SRC_A_REG,
    SRC_A_IMM,
    SRC_A_INC,
    SRC_A_DEC
  } srcA_e;

  typedef enum logic {
    SRC_B_ZERO,
    SRC_B_REG
  } srcB_e;

  typedef enum logic [1:0] {
    FN_ADD = 2'd0,
    FN_SUB = 2'd1,
    FN_AND = 2'd2,
    FN_XOR = 2'd3
  } aluFn_e;

  // Strobes from control to datapath
  typedef struct packed {
    srcA_e  selA;
    srcB_e  selB;
    aluFn_e fn;
    logic   setCc;
  } exeCtrl_t;

endpackage

// File: rtl/exe_ctrl.sv
module exe_ctrl
  import exe_pkg::*;
(
  input  logic [3:0] icode,
  input  logic [3:0] ifun,
  output exeCtrl_t   ctrl
);

  always_comb begin
    ctrl.selA  = SRC_A_ZERO;
    ctrl.selB  = SRC_B_ZERO;
    ctrl.fn    = FN_ADD;
    ctrl.setCc = 1'b0;
    case (icode)
      IC_MOVE: begin
        ctrl.selA = SRC_A_REG;
      end
      IC_IMOV: begin
        ctrl.selA = SRC_A_IMM;
      end
      IC_STORE, IC_LOAD: begin
        ctrl.selA = SRC_A_IMM;
        ctrl.selB = SRC_B_REG;
      end
      IC_ALU: begin
        ctrl.selA  = SRC_A_REG;
        ctrl.selB  = SRC_B_REG;
        ctrl.fn    = aluFn_e'(ifun[1:0]);
        ctrl.setCc = 1'b1;
      end
      IC_CALL, IC_PUSH: begin
        ctrl.selA = SRC_A_DEC;
        ctrl.selB = SRC_B_REG;
      end
      IC_RET, IC_POP: begin
        ctrl.selA = SRC_A_INC;
        ctrl.selB = SRC_B_REG;
      end
      default: begin
        ctrl.selA = SRC_A_ZERO;
        ctrl.selB = SRC_B_ZERO;
      end
    endcase
  end

endmodule

// File: rtl/exe_datapath.sv
module exe_datapath
  import exe_pkg::*;
#(
  parameter int XLEN = XLEN_DEF,
  parameter int STEP = STEP_DEF
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            stall,
  input  exeCtrl_t        ctrl,
  input  logic [XLEN-1:0] valA,
  input  logic [XLEN-1:0] valB,
  input  logic [XLEN-1:0] valC,
  output logic [XLEN-1:0] valE,
  output logic [2:0]      flags
);

  localparam int MSB = XLEN - 1;
  localparam logic [XLEN-1:0] STEP_POS = XLEN'(STEP);
  localparam logic [XLEN-1:0] STEP_NEG = ~STEP_POS + XLEN'(1);

  logic [XLEN-1:0] opA, opB;
  logic [XLEN-1:0] sumRes, diffRes;
  logic            ovf;
  logic [2:0]      nextFlags;

  always_comb begin
    case (ctrl.selA)
      SRC_A_REG: opA = valA;
      SRC_A_IMM: opA = valC;
      SRC_A_INC: opA = STEP_POS;
      SRC_A_DEC: opA = STEP_NEG;
      default:   opA = '0;
    endcase
  end

  assign opB = (ctrl.selB == SRC_B_REG) ? valB : '0;

  assign sumRes  = opB + opA;
  assign diffRes = opB - opA;

  always_comb begin
    case (ctrl.fn)
      FN_ADD: begin
        valE = sumRes;
        ovf  = (opA[MSB] == opB[MSB]) && (sumRes[MSB] != opA[MSB]);
      end
      FN_SUB: begin
        valE = diffRes;
        ovf  = (opA[MSB] != opB[MSB]) && (diffRes[MSB] != opB[MSB]);
      end
      FN_AND: begin
        valE = opB & opA;
        ovf  = 1'b0;
      end
      default: begin
        valE = opB ^ opA;
        ovf  = 1'b0;
      end
    endcase
  end

  always_comb begin
    nextFlags         = '0;
    nextFlags[ZF_BIT] = (valE == '0);
    nextFlags[SF_BIT] = valE[MSB];
    nextFlags[OF_BIT] = ovf;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= FLAGS_RESET;
    end else if (ctrl.setCc && !stall) begin
      flags <= nextFlags;
    end
  end

endmodule

// File: rtl/exe_cond.sv
module exe_cond
  import exe_pkg::*;
(
  input  logic [2:0] flags,
  input  logic [3:0] ifun,
  output logic       cnd
);

  logic zf, less;

  assign zf   = flags[ZF_BIT];
  assign less = flags[SF_BIT] ^ flags[OF_BIT];

  always_comb begin
    case (ifun)
      CC_ALWAYS: cnd = 1'b1;
      CC_LE:     cnd = less | zf;
      CC_LT:     cnd = less;
      CC_EQ:     cnd = zf;
      CC_NE:     cnd = ~zf;
      CC_GE:     cnd = ~less;
      CC_GT:     cnd = ~less & ~zf;
      default:   cnd = 1'b0;
    endcase
  end

endmodule

// File: rtl/exe_stage.sv
module exe_stage
  import exe_pkg::*;
#(
  parameter int XLEN = XLEN_DEF,
  parameter int STEP = STEP_DEF
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            stall,
  input  logic [3:0]      icode,
  input  logic [3:0]      ifun,
  input  logic [XLEN-1:0] valA,
  input  logic [XLEN-1:0] valB,
  input  logic [XLEN-1:0] valC,
  output logic [XLEN-1:0] valE,
  output logic            cnd,
  output logic [2:0]      ccFlags
);

  exeCtrl_t ctrl;

  exe_ctrl u_ctrl (
    .icode (icode),
    .ifun  (ifun),
    .ctrl  (ctrl)
  );

  exe_datapath #(.XLEN(XLEN), .STEP(STEP)) u_dp (
    .clk   (clk),
    .rst_n (rst_n),
    .stall (stall),
    .ctrl  (ctrl),
    .valA  (valA),
    .valB  (valB),
    .valC  (valC),
    .valE  (valE),
    .flags (ccFlags)
  );

  exe_cond u_cond (
    .flags (ccFlags),
    .ifun  (ifun),
    .cnd   (cnd)
  );

endmodule

// File: rtl/exe_checker.sv
module exe_checker #(
  parameter int XLEN = 64,
  parameter int STEP = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            stall,
  input logic [3:0]      icode,
  input logic [3:0]      ifun,
  input logic [XLEN-1:0] valB,
  input logic [XLEN-1:0] valE,
  input logic            cnd,
  input logic [2:0]      ccFlags
);

  // R7: flags hold unless an unstalled arithmetic instruction was captured
  p_cc_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (icode != 4'h6 || stall) |=> (ccFlags == $past(ccFlags)));

  // R6: a zero result is never also negative
  p_zf_sf_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(ccFlags[2] && ccFlags[1]));

  // R6: logic operations clear overflow
  p_logic_of_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (icode == 4'h6 && !stall && ifun[1]) |=> !ccFlags[0]);

  // R4: call and push decrement by the stack step
  p_stack_dec_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (icode == 4'h8 || icode == 4'hA) |-> (valE == valB - XLEN'(STEP)));

  // R5: idle codes produce zero
  p_idle_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (icode == 4'h0 || icode == 4'h1 || icode == 4'h7) |-> (valE == '0));

  // R9: unconditional code is always taken
  p_always_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ifun == 4'h0) |-> cnd);

endmodule

bind exe_stage exe_checker #(.XLEN(XLEN), .STEP(STEP)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .stall   (stall),
  .icode   (icode),
  .ifun    (ifun),
  .valB    (valB),
  .valE    (valE),
  .cnd     (cnd),
  .ccFlags (ccFlags)
);

// File: tb/sim_exe_stage.sv
`timescale 1ns/1ps
module sim_exe_stage;

  localparam int W = 64;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         stall = 1'b0;
  logic [3:0]   icode = 4'h1;
  logic [3:0]   ifun = 4'h0;
  logic [W-1:0] valA = '0, valB = '0, valC = '0;
  logic [W-1:0] valE;
  logic         cnd;
  logic [2:0]   ccFlags;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [2:0]   model;
  logic [W-1:0] patA [6];
  logic [W-1:0] patB [6];
  logic [W-1:0] patC [6];

  always #4 clk = ~clk;

  exe_stage u0 (
    .clk(clk), .rst_n(rst_n), .stall(stall), .icode(icode), .ifun(ifun),
    .valA(valA), .valB(valB), .valC(valC), .valE(valE), .cnd(cnd), .ccFlags(ccFlags)
  );

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act,
                     input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h (icode %h ifun %h)", req, act, exp, icode, ifun);
    end
  endtask

  function automatic logic [W-1:0] expVal(input logic [3:0] ic, input logic [3:0] fn,
      input logic [W-1:0] a, input logic [W-1:0] b, input logic [W-1:0] c);
    case (ic)
      4'h2: return a;
      4'h3: return c;
      4'h4, 4'h5: return b + c;
      4'h6: case (fn[1:0])
              2'd0: return b + a;
              2'd1: return b - a;
              2'd2: return b & a;
              default: return b ^ a;
            endcase
      4'h8, 4'hA: return b - 64'd8;
      4'h9, 4'hB: return b + 64'd8;
      default: return '0;
    endcase
  endfunction

  function automatic logic [2:0] expFlags(input logic [3:0] fn,
      input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W-1:0] t;
    bit sa, sb, st, o;
    t = expVal(4'h6, fn, a, b, '0);
    sa = $signed(a) < 0;
    sb = $signed(b) < 0;
    st = $signed(t) < 0;
    case (fn[1:0])
      2'd0: o = (sa == sb) && (st != sa);
      2'd1: o = (sa != sb) && (st != sb);
      default: o = 1'b0;
    endcase
    return {t == '0, st, o};
  endfunction

  function automatic bit expCnd(input logic [2:0] f, input logic [3:0] fn);
    bit z, l;
    z = f[2];
    l = f[1] ^ f[0];
    case (fn)
      4'd0: return 1'b1;
      4'd1: return l | z;
      4'd2: return l;
      4'd3: return z;
      4'd4: return !z;
      4'd5: return !l;
      4'd6: return !l && !z;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string reqOf(input logic [3:0] ic);
    case (ic)
      4'h6: return "R1";
      4'h2, 4'h3: return "R2";
      4'h4, 4'h5: return "R3";
      4'h8, 4'h9, 4'hA, 4'hB: return "R4";
      default: return "R5";
    endcase
  endfunction

  initial begin
    patA[0] = 64'd5;                  patB[0] = 64'd7;                  patC[0] = 64'd100;
    patA[1] = 64'd7;                  patB[1] = 64'd7;                  patC[1] = 64'hFFFF_FFFF_FFFF_FFF0;
    patA[2] = 64'd1;                  patB[2] = 64'h7FFF_FFFF_FFFF_FFFF; patC[2] = 64'd16;
    patA[3] = 64'h8000_0000_0000_0000; patB[3] = 64'h8000_0000_0000_0000; patC[3] = 64'd0;
    patA[4] = 64'd1;                  patB[4] = 64'h8000_0000_0000_0000; patC[4] = 64'h1234_5678_9ABC_DEF0;
    patA[5] = 64'h0F0F_0000_FFFF_00FF; patB[5] = 64'hFFFF_FFFF_FFFF_FFFF; patC[5] = 64'd4;

    // R8: reset value
    model = 3'b100;
    repeat (2) @(negedge clk);
    chk(ccFlags == 3'b100, "R8", W'(ccFlags), W'(3'b100));
    rst_n = 1'b1;

    // Main sweep: every pattern, instruction code and function code
    for (int p = 0; p < 6; p++) begin
      for (int ic = 0; ic < 16; ic++) begin
        for (int fn = 0; fn < 16; fn++) begin
          @(negedge clk);
          icode = 4'(ic); ifun = 4'(fn);
          valA = patA[p]; valB = patB[p]; valC = patC[p]; stall = 1'b0;
          #1;
          chk(valE == expVal(icode, ifun, valA, valB, valC), reqOf(icode), valE,
              expVal(icode, ifun, valA, valB, valC));
          chk(cnd == expCnd(model, ifun), "R9 R10", W'(cnd), W'(expCnd(model, ifun)));
          @(posedge clk);
          if (ic == 6) model = expFlags(4'(fn), patA[p], patB[p]);
          #1;
          chk(ccFlags == model, (ic == 6) ? "R6" : "R7", W'(ccFlags), W'(model));
        end
      end
    end

    // R7: stalled arithmetic instructions leave the flags alone
    for (int p = 0; p < 6; p++) begin
      for (int fn = 0; fn < 4; fn++) begin
        @(negedge clk);
        icode = 4'h6; ifun = 4'(fn); stall = 1'b1;
        valA = patA[p]; valB = patB[p];
        @(posedge clk);
        #1;
        chk(ccFlags == model, "R7 stall", W'(ccFlags), W'(model));
      end
    end
    @(negedge clk);
    stall = 1'b0;

    // R8: asynchronous reset returns flags to ZF only
    icode = 4'h6; ifun = 4'h0; valA = 64'd1; valB = 64'd2;
    @(posedge clk);
    #1;
    chk(ccFlags == 3'b000, "R6 pre-reset", W'(ccFlags), W'(3'b000));
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(ccFlags == 3'b100, "R8 async", W'(ccFlags), W'(3'b100));

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule